// File: doc/BRIEF.md
# Row Output Precharge Sequencer

This block sits next to a row-scan token register in a passive-matrix display row driver. Each clock it picks one of four drive states for every row output. In normal scanning, the row that holds the token is tied to the low-impedance return. Every other row is held at the off level, which keeps its diodes reverse-biased.

The block also provides an optional monochrome precharge. When the active-low precharge request is sampled low at a rising edge and the monochrome enable is set, the token-driven states are overridden. For one clock every row is grounded to discharge the pixels. After that, all rows are forced to the shared precharge level, except the rows flagged in the next-active vector, which stay at the off level. The override lasts until the request is sampled high again.

The phase is registered. The per-row codes are decoded from the registered phase and the present active and next-active vectors.

Top module: `row_pchg_seq`

## Requirements
- R1: While reset is asserted, and after it is released before any request is sampled, the block is in the normal phase: the state codes follow the token vectors as in R2.
- R2: In the normal phase, a row whose active bit is 1 gets code 00 (return). Every other row gets code 01 (off level). Row r's code occupies bits [2r+1:2r] of `row_state`.
- R3: A request sampled low with the monochrome enable at 1, while in the normal phase, drives every row to code 11 (discharge) in the following cycle. The discharge phase lasts exactly one cycle.
- R4: After discharge, while the request stays low and the enable stays 1, the block is in the precharge phase. Rows whose next-active bit is 1 get code 01. All other rows get code 10 (precharge level), whatever their active bit.
- R5: The precharge phase continues for as long as the request is sampled low. The first edge that samples it high returns the block to the normal phase.
- R6: While the request is high, the monochrome enable has no effect on any row code.
- R7: With the monochrome enable at 0, a low request leaves all rows in their normal token-driven codes.
- R8: If the enable is sampled 0 during discharge or precharge, the block returns to the normal phase at that edge.
- R9: A request that is low for a single sampled edge gives one discharge cycle followed directly by the normal phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the request and enable are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the normal phase |
| pchg_req_n | input | 1 | Active-low precharge request |
| mono_en | input | 1 | Monochrome precharge enable |
| active_rows | input | ROWS | Rows currently holding a scan token |
| next_rows | input | ROWS | Rows that will hold the token next |
| row_state | output | 2*ROWS | Per-row drive code: 00 return, 01 off, 10 precharge, 11 discharge |

## Verification
The bench builds the block with ROWS set to 8. This makes it cheap to give each row its own stimulus bit and to compare the whole code vector on every cycle, so rows that are both active and next-active, and empty or full token vectors, can all be placed on distinct rows. The default width of 128 is covered by elaboration only. The per-row logic is a generate replication of the same decoder, so the 8-row build exercises every phase transition and every decode branch that the wide build has.

// File: rtl/row_pchg_pkg.sv
package row_pchg_pkg;

  typedef enum logic [1:0] {
    DRV_RETURN    = 2'b00,
    DRV_OFF       = 2'b01,
    DRV_PRECHARGE = 2'b10,
    DRV_DISCHARGE = 2'b11
  } row_drv_e;

  typedef enum logic [1:0] {
    PH_NORMAL    = 2'b00,
    PH_DISCHARGE = 2'b01,
    PH_PRECHARGE = 2'b10
  } pchg_phase_e;

  // Phase reached at the next edge from the current phase and sampled controls.
  function automatic pchg_phase_e phase_step(pchg_phase_e cur, logic req_n, logic mono);
    pchg_phase_e nxt;
    if (req_n || !mono) begin
      nxt = PH_NORMAL;
    end else if (cur == PH_NORMAL) begin
      nxt = PH_DISCHARGE;
    end else begin
      nxt = PH_PRECHARGE;
    end
    return nxt;
  endfunction

  // Drive code of a single row for a given phase.
  function automatic row_drv_e row_code(pchg_phase_e ph, logic act, logic upcoming);
    row_drv_e code;
    unique case (ph)
      PH_DISCHARGE: code = DRV_DISCHARGE;
      PH_PRECHARGE: code = upcoming ? DRV_OFF : DRV_PRECHARGE;
      default:      code = act ? DRV_RETURN : DRV_OFF;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/row_pchg_phase_ctl.sv
module row_pchg_phase_ctl
  import row_pchg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pchg_req_n,
  input  logic        mono_en,
  output pchg_phase_e phase,
  output logic        in_discharge,
  output logic        in_precharge
);

  pchg_phase_e phase_q;
  pchg_phase_e phase_d;

  always_comb begin
    phase_d = phase_step(phase_q, pchg_req_n, mono_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_NORMAL;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase        = phase_q;
  assign in_discharge = (phase_q == PH_DISCHARGE);
  assign in_precharge = (phase_q == PH_PRECHARGE);

endmodule

// File: rtl/row_pchg_row_dec.sv
module row_pchg_row_dec
  import row_pchg_pkg::*;
(
  input  pchg_phase_e phase,
  input  logic        act,
  input  logic        upcoming,
  output logic [1:0]  code
);

  row_drv_e code_e;

  always_comb begin
    code_e = row_code(phase, act, upcoming);
  end

  assign code = code_e;

endmodule

// File: rtl/row_pchg_seq.sv
module row_pchg_seq
  import row_pchg_pkg::*;
#(
  parameter int ROWS = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pchg_req_n,
  input  logic                  mono_en,
  input  logic [ROWS-1:0]       active_rows,
  input  logic [ROWS-1:0]       next_rows,
  output logic [2*ROWS-1:0]     row_state
);

  localparam int CODE_W = 2;

  pchg_phase_e phase;
  logic        in_discharge;
  logic        in_precharge;

  row_pchg_phase_ctl u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .pchg_req_n   (pchg_req_n),
    .mono_en      (mono_en),
    .phase        (phase),
    .in_discharge (in_discharge),
    .in_precharge (in_precharge)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    row_pchg_row_dec u_dec (
      .phase    (phase),
      .act      (active_rows[r]),
      .upcoming (next_rows[r]),
      .code     (row_state[r*CODE_W +: CODE_W])
    );
  end

endmodule

// File: rtl/row_pchg_seq_chk.sv
module row_pchg_seq_chk #(
  parameter int ROWS = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_n,
  input logic              mono,
  input logic              in_discharge,
  input logic              in_precharge,
  input logic [ROWS-1:0]   next_rows,
  input logic [2*ROWS-1:0] row_state
);

  // R3
  discharge_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_discharge && !in_precharge && !req_n && mono) |=> in_discharge);

  // R3
  discharge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_discharge |=> !in_discharge);

  // R3
  discharge_ground_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_discharge |-> (row_state == {(2*ROWS){1'b1}}));

  // R4
  discharge_to_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_discharge && !req_n && mono) |=> in_precharge);

  // R4
  precharge_no_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_precharge |-> (row_state[1:0] == (next_rows[0] ? 2'b01 : 2'b10)));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_n |=> (!in_discharge && !in_precharge));

  // R7
  mono_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mono |=> (!in_discharge && !in_precharge));

  // R4
  phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_discharge && in_precharge));

endmodule

bind row_pchg_seq row_pchg_seq_chk #(.ROWS(ROWS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_n        (pchg_req_n),
  .mono         (mono_en),
  .in_discharge (in_discharge),
  .in_precharge (in_precharge),
  .next_rows    (next_rows),
  .row_state    (row_state)
);

// File: tb/row_pchg_seq_tb.sv
module row_pchg_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS       = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              pchg_req_n;
  logic              mono_en;
  logic [ROWS-1:0]   active_rows;
  logic [ROWS-1:0]   next_rows;
  logic [2*ROWS-1:0] row_state;

  typedef struct {
    logic [2*ROWS-1:0] exp;
    string             tag;
  } exp_item_t;

  exp_item_t q[$];
  int checks = 0;
  int fails  = 0;
  int mphase = 0;   // 0 normal, 1 discharge, 2 precharge
  bit done   = 0;

  row_pchg_seq #(.ROWS(ROWS)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pchg_req_n  (pchg_req_n),
    .mono_en     (mono_en),
    .active_rows (active_rows),
    .next_rows   (next_rows),
    .row_state   (row_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2*ROWS-1:0] model(int ph, logic [ROWS-1:0] a, logic [ROWS-1:0] n);
    logic [2*ROWS-1:0] v;
    for (int r = 0; r < ROWS; r++) begin
      if (ph == 1)      v[2*r +: 2] = 2'b11;
      else if (ph == 2) v[2*r +: 2] = n[r] ? 2'b01 : 2'b10;
      else              v[2*r +: 2] = a[r] ? 2'b00 : 2'b01;
    end
    return v;
  endfunction

  task automatic check(logic [2*ROWS-1:0] act, logic [2*ROWS-1:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: row_state=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply inputs before an edge, advance the model, queue the expectation.
  task automatic step(logic [ROWS-1:0] a, logic [ROWS-1:0] n, logic req, logic mono, string tag);
    @(negedge clk);
    active_rows = a;
    next_rows   = n;
    pchg_req_n  = req;
    mono_en     = mono;
    if (req == 1'b1 || mono == 1'b0) mphase = 0;
    else if (mphase == 0)            mphase = 1;
    else                             mphase = 2;
    q.push_back('{exp: model(mphase, a, n), tag: tag});
  endtask

  // Monitor: compare a quarter period after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_item_t it;
        it = q.pop_front();
        check(row_state, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    pchg_req_n  = 1'b0;
    mono_en     = 1'b1;
    active_rows = 8'h05;
    next_rows   = 8'h0A;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R1: held in normal phase despite a low request during reset
    check(row_state, model(0, 8'h05, 8'h0A), "R1 reset state");
    @(negedge clk);
    pchg_req_n = 1'b1;
    rst_n      = 1'b1;
    #1;
    check(row_state, model(0, 8'h05, 8'h0A), "R1 after release");

    // R2: token-driven codes, several patterns
    step(8'h01, 8'h02, 1'b1, 1'b0, "R2 row0 active");
    step(8'h80, 8'h01, 1'b1, 1'b0, "R2 row7 active");
    step(8'h11, 8'h22, 1'b1, 1'b0, "R2 dual tokens");
    step(8'h00, 8'h00, 1'b1, 1'b0, "R2 no token");
    // R6: enable toggled with request high
    step(8'h04, 8'h08, 1'b1, 1'b1, "R6 mono high req high");
    step(8'h08, 8'h10, 1'b1, 1'b1, "R6 mono high req high 2");
    // R7: low request with enable off
    step(8'h10, 8'h20, 1'b0, 1'b0, "R7 req low mono off");
    step(8'h20, 8'h40, 1'b0, 1'b0, "R7 req low mono off 2");
    // R3, R4, R5: full sequence
    step(8'h01, 8'h02, 1'b0, 1'b1, "R3 discharge");
    step(8'h01, 8'h02, 1'b0, 1'b1, "R4 precharge spares next");
    step(8'h03, 8'h06, 1'b0, 1'b1, "R4 precharge active and next overlap");
    step(8'h00, 8'hFF, 1'b0, 1'b1, "R4 precharge all next");
    step(8'hFF, 8'h00, 1'b0, 1'b1, "R5 precharge held");
    step(8'h40, 8'h80, 1'b1, 1'b1, "R5 release to normal");
    // R9: single low edge
    step(8'h02, 8'h04, 1'b0, 1'b1, "R9 pulse discharge");
    step(8'h02, 8'h04, 1'b1, 1'b1, "R9 pulse back to normal");
    // R8: enable dropped during discharge and during precharge
    step(8'h08, 8'h10, 1'b0, 1'b1, "R8 discharge");
    step(8'h08, 8'h10, 1'b0, 1'b0, "R8 mono drop in discharge");
    step(8'h08, 8'h10, 1'b0, 1'b1, "R8 re-enter discharge");
    step(8'h08, 8'h10, 1'b0, 1'b1, "R8 precharge");
    step(8'h08, 8'h10, 1'b0, 1'b0, "R8 mono drop in precharge");
    step(8'h01, 8'h01, 1'b1, 1'b0, "R2 idle");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule